// File: doc/BRIEF.md
# Calendar Clock with Wildcard Alarm

This block keeps wall-clock time and date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle `secTick` pulse starts an update. The block first raises an update-in-progress flag. After a fixed lead time it advances the whole time set by one second, rippling carries as far as the year. It then drops the flag and emits a one-cycle update-ended pulse.

Software reaches the registers through an indexed byte port, with combinational reads and clocked writes. A mode register chooses how every time field is encoded, either BCD or plain binary. The same register chooses between 24-hour hours and 12-hour hours, where the 12-hour form carries a PM flag in bit 7.

Three alarm bytes are compared with seconds, minutes and hours once the advance has landed. When all three agree, an alarm pulse fires in the same cycle as the update-ended pulse. An alarm byte whose two top bits are both 1 acts as a wildcard for its field.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00 (hour byte 00h), day of week 01h, date 01h, month 01h, year 00h, alarm bytes 00h, mode register 02h (BCD, 24-hour), and the status byte reads 00h.
- R2: The register indices are 0 seconds, 1 second alarm, 2 minutes, 3 minute alarm, 4 hours, 5 hour alarm, 6 day of week, 7 date, 8 month, 9 year, 10 status, and 11 mode. In the mode register, bit 2 set selects binary and bit 2 clear selects BCD, while bit 1 set selects 24-hour hours.
- R3: Each accepted tick adds one second. Seconds and minutes wrap from 59 to 00 and carry into the next field, and hours wrap from 23 to 00 in 24-hour mode.
- R4: On a day carry, the date returns to 01 after the last day of the month. April, June, September and November have 30 days, and February has 29 days when the year is divisible by 4 and 28 days otherwise.
- R5: When the date wraps, the month advances, and month 12 wraps to 01 with a year carry. The year wraps from 99 to 00.
- R6: Day of week runs 1 to 7 and steps on every day carry, going from 7 back to 1.
- R7: In BCD mode every field holds two decimal digits, so seconds 09h advance to 10h. In binary mode fields hold plain values, so seconds 3Bh wrap to 00h.
- R8: In 12-hour mode hours run 01 to 12 with bit 7 set for PM. 11 AM advances to 12 PM (92h in BCD), 12 PM advances to 1 PM (81h), and 11 PM advances to 12 AM (12h) with a day carry.
- R9: The alarm pulse lasts one cycle and coincides with the update-ended pulse. It fires only when the second, minute and hour alarm bytes all match the freshly advanced time.
- R10: An alarm byte in the range C0h to FFh matches any value of its field.
- R11: The status bit 7 and `updateBusy` go high on the edge that accepts a tick and stay high for LEAD_CYCLES+1 cycles. They clear on the same edge that raises the one-cycle `updateDone`.
- R12: A tick that arrives while an update is under way is ignored.
- R13: Writes to the status index are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse requesting a one-second advance |
| regAddr | input | ADDR_W | Register index for reads and writes |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| updateBusy | output | 1 | Update-in-progress flag |
| updateDone | output | 1 | One-cycle pulse when an update has completed |
| alarmHit | output | 1 | One-cycle alarm pulse |

## Verification
The assertions take for granted that software does not write the time registers or the mode register while `updateBusy` is high. This is because the advance takes priority over any write landing in its cycle, and time data is undefined during that window. The seconds range check also relies on the mode not changing between an advance and the cycle after it. The stimulus waits for `updateDone` before every register access, so all writes fall strictly between updates. It raises a second tick inside the busy window in only one place, and that is deliberate, to exercise the ignore rule.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int BYTE_W = 8;

  localparam int IDX_SEC    = 0;
  localparam int IDX_ASEC   = 1;
  localparam int IDX_MIN    = 2;
  localparam int IDX_AMIN   = 3;
  localparam int IDX_HOUR   = 4;
  localparam int IDX_AHOUR  = 5;
  localparam int IDX_DOW    = 6;
  localparam int IDX_DATE   = 7;
  localparam int IDX_MONTH  = 8;
  localparam int IDX_YEAR   = 9;
  localparam int IDX_STATUS = 10;
  localparam int IDX_MODE   = 11;

  localparam int MODE_BIN_BIT = 2;
  localparam int MODE_24H_BIT = 1;
  localparam logic [BYTE_W-1:0] MODE_RESET = 8'h02;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic advance;  // apply the one-second increment this cycle
    logic finish;   // update complete: evaluate alarm, emit done
  } updStrobe_t;

  function automatic logic [7:0] decodeField(input logic [7:0] raw, input logic binMode);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = {4'b0, raw[7:4]};
    ones = {4'b0, raw[3:0]};
    return binMode ? raw : (tens * 8'd10 + ones);
  endfunction

  function automatic logic [7:0] encodeField(input logic [7:0] val, input logic binMode);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = val / 8'd10;
    ones = val % 8'd10;
    return binMode ? val : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] month, input logic [7:0] year);
    case (month)
      8'd2:                      return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int LEAD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  output logic       uipFlag,
  output updStrobe_t strb
);

  localparam int CNT_W = $clog2(LEAD_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LEAD_CYCLES - 1);

  typedef enum logic [1:0] { ST_IDLE, ST_LEAD, ST_FINISH } seqState_t;

  seqState_t       stateQ;
  logic [CNT_W-1:0] leadCnt;

  always_comb begin
    strb.advance = (stateQ == ST_LEAD) && (leadCnt == '0);
    strb.finish  = (stateQ == ST_FINISH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      leadCnt <= '0;
      uipFlag <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: if (secTick) begin
          stateQ  <= ST_LEAD;
          leadCnt <= CNT_LOAD;
          uipFlag <= 1'b1;
        end
        ST_LEAD: begin
          if (leadCnt == '0) stateQ <= ST_FINISH;
          else               leadCnt <= leadCnt - 1'b1;
        end
        ST_FINISH: begin
          stateQ  <= ST_IDLE;
          uipFlag <= 1'b0;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R11: advance only happens inside the busy window
  p_adv_in_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> uipFlag);

  // R11: finish follows advance by exactly one cycle
  p_finish_after_adv_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> strb.finish);

  // R12: busy flag cannot drop (or be restarted) before the finish cycle
  p_busy_holds_r12: assert property (@(posedge clk) disable iff (!rstN)
    (uipFlag && !strb.finish) |=> uipFlag);

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  updStrobe_t        strb,
  input  logic              uipFlag,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              updEndPulse,
  output logic              alarmPulse
);

  logic [7:0] secR, minR, hourR, dowR, dateR, monR, yearR;
  logic [7:0] aSecR, aMinR, aHourR, modeR;

  logic binMode, h24Mode;
  assign binMode = modeR[MODE_BIN_BIT];
  assign h24Mode = modeR[MODE_24H_BIT];

  // ---------------- increment network ----------------
  logic [7:0] secV, minV, h12Raw, hr24Cur, dowV, dateV, monV, yearV, mLen;
  logic [7:0] secN, minN, hr24N, h12N, dowN, dateN, monN, yearN, hourEnc, hEnc12;
  logic       secWrap, hourCarry, dayCarry, monCarry, yearCarry;

  always_comb begin
    secV   = decodeField(secR, binMode);
    minV   = decodeField(minR, binMode);
    h12Raw = decodeField({1'b0, hourR[6:0]}, binMode);
    if (h24Mode) hr24Cur = decodeField(hourR, binMode);
    else         hr24Cur = ((h12Raw == 8'd12) ? 8'd0 : h12Raw) + (hourR[7] ? 8'd12 : 8'd0);
    dowV   = decodeField(dowR, binMode);
    dateV  = decodeField(dateR, binMode);
    monV   = decodeField(monR, binMode);
    yearV  = decodeField(yearR, binMode);
    mLen   = monthDays(monV, yearV);

    secWrap   = (secV >= 8'd59);
    secN      = secWrap ? 8'd0 : secV + 8'd1;
    hourCarry = secWrap && (minV >= 8'd59);
    minN      = (minV >= 8'd59) ? 8'd0 : minV + 8'd1;
    dayCarry  = hourCarry && (hr24Cur >= 8'd23);
    hr24N     = (hr24Cur >= 8'd23) ? 8'd0 : hr24Cur + 8'd1;
    dowN      = (dowV >= 8'd7) ? 8'd1 : dowV + 8'd1;
    monCarry  = dayCarry && (dateV >= mLen);
    dateN     = (dateV >= mLen) ? 8'd1 : dateV + 8'd1;
    yearCarry = monCarry && (monV >= 8'd12);
    monN      = (monV >= 8'd12) ? 8'd1 : monV + 8'd1;
    yearN     = (yearV >= 8'd99) ? 8'd0 : yearV + 8'd1;

    h12N   = ((hr24N % 8'd12) == 8'd0) ? 8'd12 : (hr24N % 8'd12);
    hEnc12 = encodeField(h12N, binMode);
    hourEnc = h24Mode ? encodeField(hr24N, binMode) : {hr24N >= 8'd12, hEnc12[6:0]};
  end

  // ---------------- register file ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secR <= '0; minR <= '0; hourR <= '0; dowR <= 8'd1;
      dateR <= 8'd1; monR <= 8'd1; yearR <= '0;
      aSecR <= '0; aMinR <= '0; aHourR <= '0; modeR <= MODE_RESET;
    end else if (strb.advance) begin
      secR <= encodeField(secN, binMode);
      if (secWrap)   minR  <= encodeField(minN, binMode);
      if (hourCarry) hourR <= hourEnc;
      if (dayCarry) begin
        dowR  <= encodeField(dowN, binMode);
        dateR <= encodeField(dateN, binMode);
      end
      if (monCarry)  monR  <= encodeField(monN, binMode);
      if (yearCarry) yearR <= encodeField(yearN, binMode);
    end else if (regWrEn) begin
      case (int'(regAddr))
        IDX_SEC:   secR   <= regWrData;
        IDX_ASEC:  aSecR  <= regWrData;
        IDX_MIN:   minR   <= regWrData;
        IDX_AMIN:  aMinR  <= regWrData;
        IDX_HOUR:  hourR  <= regWrData;
        IDX_AHOUR: aHourR <= regWrData;
        IDX_DOW:   dowR   <= regWrData;
        IDX_DATE:  dateR  <= regWrData;
        IDX_MONTH: monR   <= regWrData;
        IDX_YEAR:  yearR  <= regWrData;
        IDX_MODE:  modeR  <= regWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (int'(regAddr))
      IDX_SEC:    regRdData = secR;
      IDX_ASEC:   regRdData = aSecR;
      IDX_MIN:    regRdData = minR;
      IDX_AMIN:   regRdData = aMinR;
      IDX_HOUR:   regRdData = hourR;
      IDX_AHOUR:  regRdData = aHourR;
      IDX_DOW:    regRdData = dowR;
      IDX_DATE:   regRdData = dateR;
      IDX_MONTH:  regRdData = monR;
      IDX_YEAR:   regRdData = yearR;
      IDX_STATUS: regRdData = {uipFlag, 7'b0};
      IDX_MODE:   regRdData = modeR;
      default:    regRdData = '0;
    endcase
  end

  // ---------------- alarm compare ----------------
  logic [2:0] fieldHit;
  always_comb begin
    fieldHit[0] = (aSecR[7:6]  == 2'b11) || (aSecR  == secR);
    fieldHit[1] = (aMinR[7:6]  == 2'b11) || (aMinR  == minR);
    fieldHit[2] = (aHourR[7:6] == 2'b11) || (aHourR == hourR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updEndPulse <= 1'b0;
      alarmPulse  <= 1'b0;
    end else begin
      updEndPulse <= strb.finish;
      alarmPulse  <= strb.finish && (&fieldHit);
    end
  end

  // R3: an advance always leaves seconds in range
  p_sec_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (decodeField(secR, binMode) < 8'd60));

  // R3: seconds hold when neither advanced nor written
  p_sec_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !regWrEn) |=> $stable(secR));

  // R9: alarm pulse only with the update-ended pulse
  p_alarm_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    alarmPulse |-> updEndPulse);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int LEAD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              updateBusy,
  output logic              updateDone,
  output logic              alarmHit
);

  updStrobe_t strb;

  rtc_cal_ctrl #(.LEAD_CYCLES(LEAD_CYCLES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .secTick (secTick),
    .uipFlag (updateBusy),
    .strb    (strb)
  );

  rtc_cal_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .uipFlag     (updateBusy),
    .regAddr     (regAddr),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .updEndPulse (updateDone),
    .alarmPulse  (alarmHit)
  );

  // R11: busy flag is already low when the done pulse shows
  p_busy_clear_at_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    updateDone |-> !updateBusy);

  // R11: done pulse lasts one cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    updateDone |=> !updateDone);

endmodule

// File: tb/rtc_calendar_tb_top.sv
module rtc_calendar_tb_top;

  localparam int ADDR_W = 4;
  localparam int LEAD   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic updateBusy, updateDone, alarmHit;

  int testsRun = 0;
  int testsFailed = 0;
  bit expAlarmQ[$];

  always #5 clk = ~clk;

  rtc_calendar #(.ADDR_W(ADDR_W), .LEAD_CYCLES(LEAD)) dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .updateBusy(updateBusy), .updateDone(updateDone), .alarmHit(alarmHit)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wrReg(input int idx, input logic [7:0] d);
    @(negedge clk);
    regAddr = ADDR_W'(idx); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input int idx, output logic [7:0] d);
    regAddr = ADDR_W'(idx);
    #1;
    d = regRdData;
  endtask

  task automatic checkReg(input string tag, input int idx, input logic [7:0] exp);
    logic [7:0] v;
    rdReg(idx, v);
    check(tag, v, exp);
  endtask

  task automatic setTime(input logic [7:0] mode, input logic [7:0] s, input logic [7:0] m,
                         input logic [7:0] h, input logic [7:0] dw, input logic [7:0] dt,
                         input logic [7:0] mo, input logic [7:0] yr);
    wrReg(11, mode);
    wrReg(0, s); wrReg(2, m); wrReg(4, h);
    wrReg(6, dw); wrReg(7, dt); wrReg(8, mo); wrReg(9, yr);
  endtask

  task automatic setAlarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    wrReg(1, s); wrReg(3, m); wrReg(5, h);
  endtask

  // Driver: push expected alarm outcome, pulse tick, check busy window length (R11)
  task automatic doTick(input bit expAlarm);
    int busyCycles;
    expAlarmQ.push_back(expAlarm);
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    busyCycles = 0;
    while (!updateDone) begin
      if (updateBusy) busyCycles++;
      @(negedge clk);
    end
    check("R11 busy cycles", 8'(busyCycles), 8'(LEAD + 1));
    @(negedge clk);
    check("R11 done single cycle", {7'b0, updateDone}, 8'h00);
  endtask

  // Monitor: pop expected alarm at each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && updateDone) begin
        check("R11 busy low at done", {7'b0, updateBusy}, 8'h00);
        if (expAlarmQ.size() == 0) begin
          testsRun++; testsFailed++;
          $display("FAIL R12 unexpected update actual 1 expected 0");
        end else begin
          bit e;
          e = expAlarmQ.pop_front();
          check("R9 R10 alarm", {7'b0, alarmHit}, {7'b0, e});
        end
      end else if (rstN && alarmHit) begin
        testsRun++; testsFailed++;
        $display("FAIL R9 alarm without done actual 1 expected 0");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkReg("R1 sec", 0, 8'h00);
    checkReg("R1 min", 2, 8'h00);
    checkReg("R1 hour", 4, 8'h00);
    checkReg("R1 dow", 6, 8'h01);
    checkReg("R1 date", 7, 8'h01);
    checkReg("R1 month", 8, 8'h01);
    checkReg("R1 year", 9, 8'h00);
    checkReg("R1 alarm sec", 1, 8'h00);
    checkReg("R1 mode", 11, 8'h02);
    checkReg("R1 status", 10, 8'h00);
    check("R1 busy", {7'b0, updateBusy}, 8'h00);

    setAlarm(8'h01, 8'h01, 8'h01);

    // R3 R5 R6 R2: full rollover in BCD 24h
    setTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    doTick(1'b0);
    checkReg("R3 sec wrap", 0, 8'h00);
    checkReg("R3 min wrap", 2, 8'h00);
    checkReg("R3 hour wrap", 4, 8'h00);
    checkReg("R6 dow 7 to 1", 6, 8'h01);
    checkReg("R5 date", 7, 8'h01);
    checkReg("R5 month wrap", 8, 8'h01);
    checkReg("R5 year wrap", 9, 8'h00);

    // R7 BCD digit carry
    setTime(8'h02, 8'h09, 8'h14, 8'h08, 8'h03, 8'h10, 8'h06, 8'h45);
    doTick(1'b0);
    checkReg("R7 bcd sec 09->10", 0, 8'h10);
    checkReg("R3 min held", 2, 8'h14);

    // R4 leap year February
    setTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    doTick(1'b0);
    checkReg("R4 leap date 29", 7, 8'h29);
    checkReg("R4 leap month", 8, 8'h02);
    checkReg("R6 dow step", 6, 8'h03);
    setTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    doTick(1'b0);
    checkReg("R4 leap end date", 7, 8'h01);
    checkReg("R4 leap end month", 8, 8'h03);

    // R4 non-leap February
    setTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    doTick(1'b0);
    checkReg("R4 nonleap date", 7, 8'h01);
    checkReg("R4 nonleap month", 8, 8'h03);

    // R4 R7 binary mode, 30-day month
    setTime(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h04, 8'h1E, 8'h04, 8'h17);
    doTick(1'b0);
    checkReg("R7 bin sec wrap", 0, 8'h00);
    checkReg("R7 bin hour wrap", 4, 8'h00);
    checkReg("R4 april end date", 7, 8'h01);
    checkReg("R4 april end month", 8, 8'h05);
    setTime(8'h06, 8'h3B, 8'h0A, 8'h05, 8'h04, 8'h0F, 8'h04, 8'h17);
    doTick(1'b0);
    checkReg("R7 bin min carry", 2, 8'h0B);

    // R8 12-hour mode, BCD
    setTime(8'h00, 8'h59, 8'h59, 8'h11, 8'h02, 8'h05, 8'h03, 8'h30);
    doTick(1'b0);
    checkReg("R8 11AM to 12PM", 4, 8'h92);
    setTime(8'h00, 8'h59, 8'h59, 8'h92, 8'h02, 8'h05, 8'h03, 8'h30);
    doTick(1'b0);
    checkReg("R8 12PM to 1PM", 4, 8'h81);
    setTime(8'h00, 8'h59, 8'h59, 8'h91, 8'h02, 8'h05, 8'h03, 8'h30);
    doTick(1'b0);
    checkReg("R8 11PM to 12AM", 4, 8'h12);
    checkReg("R8 day carry date", 7, 8'h06);
    checkReg("R8 day carry dow", 6, 8'h03);

    // R9 exact alarm
    setTime(8'h02, 8'h29, 8'h20, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    setAlarm(8'h30, 8'h20, 8'h10);
    doTick(1'b1);
    doTick(1'b0);
    // R10 wildcard minute/hour, exact second 32
    setAlarm(8'h32, 8'hC0, 8'hFF);
    doTick(1'b1);
    // R9 partial match: minute mismatches
    setAlarm(8'h33, 8'h21, 8'hFF);
    doTick(1'b0);
    // R10 all wildcards
    setAlarm(8'hC5, 8'hFE, 8'hC0);
    doTick(1'b1);

    // R11 status reads busy inside the window; R13 status write ignored
    setAlarm(8'h01, 8'h01, 8'h01);
    setTime(8'h02, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    expAlarmQ.push_back(1'b0);
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    checkReg("R11 status busy", 10, 8'h80);
    // R12 second tick inside the busy window
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    while (!updateDone) @(negedge clk);
    repeat (LEAD + 6) @(negedge clk);
    checkReg("R12 only one second added", 0, 8'h01);
    checkReg("R11 status idle", 10, 8'h00);
    wrReg(10, 8'hFF);
    checkReg("R13 status write ignored", 10, 8'h00);
    check("R13 busy unaffected", {7'b0, updateBusy}, 8'h00);

    repeat (5) @(negedge clk);
    check("R12 scoreboard drained", 8'(expAlarmQ.size()), 8'h00);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule